// File: doc/BRIEF.md
# Oversampling Serial Receiver with Error-Tagged FIFO

This block is the receive side of an asynchronous serial port. A baud generator outside the block supplies a one-cycle tick at sixteen times the bit rate. The receiver synchronizes the serial line and watches for a falling edge. It confirms the start bit at its centre and then samples every data, parity and stop bit at the centre of the bit. It checks parity against the configured sense and checks the first stop bit. It also recognises a break, which is a line held low through a whole character.

Each finished character goes into a sixteen-entry FIFO together with its own parity, framing and break flags. The host sees the flags only when that character reaches the head of the FIFO. The host reads the head and pulses a pop strobe to remove it. A status strobe clears the sticky overrun indication.

The data-ready output compares the FIFO occupancy with a selectable trigger level. A summary output reports whether any stored entry carries an error. When FIFO mode is off, the store holds a single character.

Top module: `rx_core`

## Requirements
- R1: After reset, data_ready, overrun and any_err are 0, and the head outputs (rd_data, head_pe, head_fe, head_bi) are all 0.
- R2: Bits are received least significant first. The word length code wlen selects the number of data bits: 00 gives 5, 01 gives 6, 10 gives 7 and 11 gives 8. Unused upper bits of rd_data read as 0.
- R3: When par_en is 1, a parity bit follows the data bits. With par_even=1, data plus parity must hold an even number of ones; with par_even=0, an odd number. On a mismatch, head_pe is 1 for that character.
- R4: Only the first stop bit is examined. If it is sampled low, head_fe is 1 for that character. A new start bit that follows the first stop bit directly is received.
- R5: A low pulse that is no longer high-free than half a bit time is not a start bit: the line must still be low at the start-bit centre, otherwise no character is stored.
- R6: A frame whose data, parity and stop samples are all low is a break. It stores exactly one entry, with data 0, head_bi=1 and head_fe=0. Nothing more is stored until the line has gone high and a valid start bit follows.
- R7: The error flags belong to individual entries. head_pe, head_fe and head_bi show the flags of the character currently at the head only.
- R8: A character that completes while the FIFO is full is discarded, and overrun becomes 1. The stored entries are unchanged. A stat_rd pulse clears overrun.
- R9: A pop while the FIFO is empty leaves the read position unchanged.
- R10: In FIFO mode, data_ready is 1 when the occupancy is at least the level chosen by trig: 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 12.
- R11: any_err is 1 in FIFO mode whenever any stored entry has a flag set. It is 0 in non-FIFO mode.
- R12: With fifo_mode=0, the store holds one character and data_ready means it is non-empty. A second character that arrives before the pop is discarded and sets overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| tick16 | input | 1 | One-cycle pulse at 16x the bit rate |
| rxd | input | 1 | Serial line, idle high |
| wlen | input | 2 | Data bits: 00=5, 01=6, 10=7, 11=8 |
| par_en | input | 1 | Parity bit present and checked |
| par_even | input | 1 | 1 = even parity, 0 = odd parity |
| fifo_mode | input | 1 | 1 = 16-entry store, 0 = single entry |
| trig | input | 2 | Ready level: 00=1, 01=4, 10=8, 11=12 |
| rd_pop | input | 1 | Remove the head entry |
| stat_rd | input | 1 | Status read, clears overrun |
| rd_data | output | 8 | Data of the head entry |
| head_pe | output | 1 | Parity flag of the head entry |
| head_fe | output | 1 | Framing flag of the head entry |
| head_bi | output | 1 | Break flag of the head entry |
| data_ready | output | 1 | Occupancy at or above the trigger level |
| overrun | output | 1 | Sticky: a character was discarded |
| any_err | output | 1 | Some stored entry has a flag set |

## Verification
A character's entry is registered one clock after the tick that samples the centre of its stop bit. The occupancy, the head outputs, data_ready and any_err follow one clock after that. The bench therefore reads these results only after the whole stop bit and its idle time have been driven, which is many clocks past that point.

A pop or a status read takes effect on the next rising edge. The bench drives these strobes at a falling edge and samples at the following falling edge, so each check sees the updated state and no edge race can affect it.

// File: rtl/rx_core_pkg.sv
package rx_core_pkg;

    typedef struct packed {
        logic [7:0] data;
        logic       pe;
        logic       fe;
        logic       bi;
    } rx_ent_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_DATA,
        S_PAR,
        S_STOP,
        S_WAITHI
    } rx_st_t;

    function automatic logic [3:0] word_bits(input logic [1:0] code);
        return 4'(code) + 4'd5;
    endfunction

    function automatic logic [4:0] trig_level(input logic [1:0] code);
        case (code)
            2'b00:   return 5'd1;
            2'b01:   return 5'd4;
            2'b10:   return 5'd8;
            default: return 5'd12;
        endcase
    endfunction

    function automatic logic ent_err(input rx_ent_t e);
        return e.pe | e.fe | e.bi;
    endfunction

endpackage

// File: rtl/rx_frame.sv
module rx_frame
    import rx_core_pkg::*;
#(
    parameter int OVS  = 16,
    parameter int SYNC = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       rxd,
    input  logic [1:0] wlen,
    input  logic       par_en,
    input  logic       par_even,
    output logic       push,
    output rx_ent_t    pkt
);
    localparam int TW = $clog2(OVS);
    localparam logic [TW-1:0] MID  = TW'(OVS / 2 - 1);
    localparam logic [TW-1:0] LAST = TW'(OVS - 1);

    logic [SYNC-1:0] sy;
    logic            rx;
    rx_st_t          st;
    logic [TW-1:0]   tcnt;
    logic [2:0]      bidx;
    logic [7:0]      shd;
    logic            allz;
    logic            parbit;
    logic            last_bit;
    logic            par_bad;

    always_ff @(posedge clk) begin
        if (rst) sy <= '1;
        else     sy <= {sy[SYNC-2:0], rxd};
    end
    assign rx = sy[SYNC-1];

    assign last_bit = (bidx == 3'(word_bits(wlen) - 4'd1));
    assign par_bad  = par_en && (((^shd) ^ parbit) == par_even);

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= S_IDLE;
            tcnt   <= '0;
            bidx   <= '0;
            shd    <= '0;
            allz   <= 1'b0;
            parbit <= 1'b0;
            push   <= 1'b0;
            pkt    <= '0;
        end else begin
            push <= 1'b0;
            if (tick) begin
                case (st)
                    S_IDLE: begin
                        tcnt <= '0;
                        if (!rx) st <= S_START;
                    end
                    S_START: begin
                        if (tcnt == MID) begin
                            tcnt <= '0;
                            if (!rx) begin
                                st   <= S_DATA;
                                bidx <= '0;
                                shd  <= '0;
                                allz <= 1'b1;
                            end else begin
                                st <= S_IDLE;
                            end
                        end else begin
                            tcnt <= tcnt + 1'b1;
                        end
                    end
                    S_DATA: begin
                        if (tcnt == LAST) begin
                            tcnt      <= '0;
                            shd[bidx] <= rx;
                            allz      <= allz & ~rx;
                            if (last_bit) st <= par_en ? S_PAR : S_STOP;
                            else          bidx <= bidx + 1'b1;
                        end else begin
                            tcnt <= tcnt + 1'b1;
                        end
                    end
                    S_PAR: begin
                        if (tcnt == LAST) begin
                            tcnt   <= '0;
                            parbit <= rx;
                            allz   <= allz & ~rx;
                            st     <= S_STOP;
                        end else begin
                            tcnt <= tcnt + 1'b1;
                        end
                    end
                    S_STOP: begin
                        if (tcnt == LAST) begin
                            tcnt <= '0;
                            push <= 1'b1;
                            if (!rx && allz) begin
                                pkt <= '{data: 8'h00, pe: 1'b0, fe: 1'b0, bi: 1'b1};
                                st  <= S_WAITHI;
                            end else begin
                                pkt <= '{data: shd, pe: par_bad, fe: ~rx, bi: 1'b0};
                                st  <= rx ? S_IDLE : S_WAITHI;
                            end
                        end else begin
                            tcnt <= tcnt + 1'b1;
                        end
                    end
                    S_WAITHI: begin
                        if (rx) st <= S_IDLE;
                    end
                    default: st <= S_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/rx_err_fifo.sv
module rx_err_fifo
    import rx_core_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int AW    = $clog2(DEPTH),
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  rx_ent_t       pkt_in,
    input  logic          pop,
    input  logic          stat_rd,
    input  logic          fifo_mode,
    input  logic [1:0]    trig,
    output rx_ent_t       head,
    output logic [CW-1:0] cnt,
    output logic          full,
    output logic          data_ready,
    output logic          overrun,
    output logic          any_err
);
    rx_ent_t       mem [DEPTH];
    logic [AW-1:0] wptr;
    logic [AW-1:0] rptr;
    logic [CW-1:0] errcnt;
    logic          empty;
    logic          do_wr;
    logic          do_rd;
    logic          err_in;
    logic          err_out;

    assign empty   = (cnt == '0);
    assign full    = fifo_mode ? (cnt == CW'(DEPTH)) : !empty;
    assign do_wr   = push && !full;
    assign do_rd   = pop && !empty;
    assign head    = empty ? '0 : mem[rptr];
    assign err_in  = do_wr && ent_err(pkt_in);
    assign err_out = do_rd && ent_err(head);

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_wr) mem[wptr] <= pkt_in;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr    <= '0;
            rptr    <= '0;
            cnt     <= '0;
            errcnt  <= '0;
            overrun <= 1'b0;
        end else begin
            if (do_wr) wptr <= nxt(wptr);
            if (do_rd) rptr <= nxt(rptr);
            case ({do_wr, do_rd})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
            case ({err_in, err_out})
                2'b10:   errcnt <= errcnt + 1'b1;
                2'b01:   errcnt <= errcnt - 1'b1;
                default: errcnt <= errcnt;
            endcase
            if (push && full) overrun <= 1'b1;
            else if (stat_rd) overrun <= 1'b0;
        end
    end

    assign data_ready = fifo_mode ? (cnt >= CW'(trig_level(trig))) : !empty;
    assign any_err    = fifo_mode && (errcnt != '0);

endmodule

// File: rtl/rx_core.sv
module rx_core
    import rx_core_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int OVS   = 16,
    parameter int SYNC  = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick16,
    input  logic       rxd,
    input  logic [1:0] wlen,
    input  logic       par_en,
    input  logic       par_even,
    input  logic       fifo_mode,
    input  logic [1:0] trig,
    input  logic       rd_pop,
    input  logic       stat_rd,
    output logic [7:0] rd_data,
    output logic       head_pe,
    output logic       head_fe,
    output logic       head_bi,
    output logic       data_ready,
    output logic       overrun,
    output logic       any_err
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic          frm_push;
    rx_ent_t       frm_pkt;
    rx_ent_t       head;
    logic [CW-1:0] fifo_cnt;
    logic          fifo_full;

    rx_frame #(.OVS(OVS), .SYNC(SYNC)) u_frame (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick16),
        .rxd      (rxd),
        .wlen     (wlen),
        .par_en   (par_en),
        .par_even (par_even),
        .push     (frm_push),
        .pkt      (frm_pkt)
    );

    rx_err_fifo #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_fifo (
        .clk        (clk),
        .rst        (rst),
        .push       (frm_push),
        .pkt_in     (frm_pkt),
        .pop        (rd_pop),
        .stat_rd    (stat_rd),
        .fifo_mode  (fifo_mode),
        .trig       (trig),
        .head       (head),
        .cnt        (fifo_cnt),
        .full       (fifo_full),
        .data_ready (data_ready),
        .overrun    (overrun),
        .any_err    (any_err)
    );

    assign rd_data = head.data;
    assign head_pe = head.pe;
    assign head_fe = head.fe;
    assign head_bi = head.bi;

endmodule

// File: rtl/rx_core_chk.sv
module rx_core_chk #(
    parameter int DEPTH = 16,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          frm_push,
    input logic          frm_bi,
    input logic [7:0]    frm_data,
    input logic          fifo_full,
    input logic [CW-1:0] fifo_cnt,
    input logic          rd_pop,
    input logic          overrun,
    input logic          data_ready
);
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (!overrun && !data_ready));

    p_push_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        frm_push |=> !frm_push);

    p_break_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (frm_push && frm_bi) |-> (frm_data == 8'h00));

    p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
        fifo_cnt <= CW'(DEPTH));

    p_ovr_set_r8: assert property (@(posedge clk) disable iff (rst)
        (frm_push && fifo_full) |=> overrun);

    p_empty_pop_r9: assert property (@(posedge clk) disable iff (rst)
        ((fifo_cnt == '0) && rd_pop && !frm_push) |=> (fifo_cnt == '0));

    p_ready_nonempty_r10: assert property (@(posedge clk) disable iff (rst)
        data_ready |-> (fifo_cnt != '0));

endmodule

bind rx_core rx_core_chk #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .frm_push   (frm_push),
    .frm_bi     (frm_pkt.bi),
    .frm_data   (frm_pkt.data),
    .fifo_full  (fifo_full),
    .fifo_cnt   (fifo_cnt),
    .rd_pop     (rd_pop),
    .overrun    (overrun),
    .data_ready (data_ready)
);

// File: tb/rx_core_tb.sv
`timescale 1ns/1ps
module rx_core_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick16 = 1'b0;
    logic       rxd = 1'b1;
    logic [1:0] wlen = 2'b11;
    logic       par_en = 1'b0;
    logic       par_even = 1'b0;
    logic       fifo_mode = 1'b1;
    logic [1:0] trig = 2'b00;
    logic       rd_pop = 1'b0;
    logic       stat_rd = 1'b0;
    logic [7:0] rd_data;
    logic       head_pe, head_fe, head_bi;
    logic       data_ready, overrun, any_err;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    always @(posedge clk) tick16 <= rst ? 1'b0 : ~tick16;

    rx_core u_dut (
        .clk(clk), .rst(rst), .tick16(tick16), .rxd(rxd), .wlen(wlen),
        .par_en(par_en), .par_even(par_even), .fifo_mode(fifo_mode),
        .trig(trig), .rd_pop(rd_pop), .stat_rd(stat_rd), .rd_data(rd_data),
        .head_pe(head_pe), .head_fe(head_fe), .head_bi(head_bi),
        .data_ready(data_ready), .overrun(overrun), .any_err(any_err)
    );

    // fields: wlen[23:22] pen[21] peven[20] badpar[19] stop[18]
    //         data[17:10] expdata[9:2] exp_pe[1] exp_fe[0]
    localparam logic [23:0] VEC [10] = '{
        {2'b11, 1'b0, 1'b0, 1'b0, 1'b1, 8'hA5, 8'hA5, 1'b0, 1'b0},
        {2'b00, 1'b0, 1'b0, 1'b0, 1'b1, 8'hFF, 8'h1F, 1'b0, 1'b0},
        {2'b01, 1'b0, 1'b0, 1'b0, 1'b1, 8'hC3, 8'h03, 1'b0, 1'b0},
        {2'b10, 1'b0, 1'b0, 1'b0, 1'b1, 8'hD5, 8'h55, 1'b0, 1'b0},
        {2'b11, 1'b1, 1'b1, 1'b0, 1'b1, 8'h3C, 8'h3C, 1'b0, 1'b0},
        {2'b11, 1'b1, 1'b1, 1'b1, 1'b1, 8'h3C, 8'h3C, 1'b1, 1'b0},
        {2'b11, 1'b1, 1'b0, 1'b0, 1'b1, 8'h01, 8'h01, 1'b0, 1'b0},
        {2'b11, 1'b1, 1'b0, 1'b1, 1'b1, 8'h01, 8'h01, 1'b1, 1'b0},
        {2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 8'h55, 8'h55, 1'b0, 1'b1},
        {2'b00, 1'b1, 1'b1, 1'b0, 1'b1, 8'h0A, 8'h0A, 1'b0, 1'b0}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic drive_bit(input logic b);
        rxd = b;
        repeat (32) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] d, input bit badpar, input bit stopv, input int idle);
        int nb;
        logic [7:0] m;
        logic p;
        nb = int'(wlen) + 5;
        m  = d & 8'((9'd1 << nb) - 9'd1);
        p  = par_even ? ^m : ~^m;
        if (badpar) p = ~p;
        drive_bit(1'b0);
        for (int i = 0; i < nb; i++) drive_bit(m[i]);
        if (par_en) drive_bit(p);
        drive_bit(stopv);
        for (int i = 0; i < idle; i++) drive_bit(1'b1);
    endtask

    task automatic pop();
        @(negedge clk) rd_pop = 1'b1;
        @(negedge clk) rd_pop = 1'b0;
    endtask

    task automatic status_read();
        @(negedge clk) stat_rd = 1'b1;
        @(negedge clk) stat_rd = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 data_ready", data_ready, 0);
        check("R1 overrun", overrun, 0);
        check("R1 any_err", any_err, 0);
        check("R1 head", {rd_data, head_pe, head_fe, head_bi}, 0);

        // table of frames: R2 word lengths, R3 parity, R4 framing
        for (int k = 0; k < 10; k++) begin
            wlen     = VEC[k][23:22];
            par_en   = VEC[k][21];
            par_even = VEC[k][20];
            send(VEC[k][17:10], VEC[k][19], VEC[k][18], 2);
            check("R2 data", rd_data, VEC[k][9:2]);
            check("R3 parity flag", head_pe, VEC[k][1]);
            check("R4 framing flag", head_fe, VEC[k][0]);
            check("R2 no break", head_bi, 0);
            pop();
            check("R2 drained", data_ready, 0);
        end
        wlen = 2'b11; par_en = 1'b0; par_even = 1'b0;

        // R4 back-to-back frames after a single stop bit
        send(8'h31, 0, 1, 0);
        send(8'h32, 0, 1, 2);
        check("R4 first", rd_data, 8'h31);
        pop();
        check("R4 second", rd_data, 8'h32);
        pop();

        // R5 short low glitch
        rxd = 1'b0;
        repeat (12) @(negedge clk);
        rxd = 1'b1;
        repeat (320) @(negedge clk);
        check("R5 glitch ignored", data_ready, 0);

        // R7 / R11 per-entry flags
        par_en = 1'b1; par_even = 1'b1;
        send(8'h41, 0, 1, 1);
        send(8'h42, 1, 1, 2);
        check("R7 head clean", {rd_data, head_pe}, {8'h41, 1'b0});
        check("R11 any_err set", any_err, 1);
        pop();
        check("R7 head bad", {rd_data, head_pe}, {8'h42, 1'b1});
        pop();
        check("R11 any_err clear", any_err, 0);
        par_en = 1'b0;

        // R6 break
        for (int i = 0; i < 30; i++) drive_bit(1'b0);
        drive_bit(1'b1);
        drive_bit(1'b1);
        check("R6 break entry", {rd_data, head_pe, head_fe, head_bi}, {8'h00, 3'b001});
        pop();
        check("R6 single entry", data_ready, 0);
        send(8'h5A, 0, 1, 2);
        check("R6 resume", {rd_data, head_bi}, {8'h5A, 1'b0});
        pop();

        // R10 trigger levels
        trig = 2'b01;
        for (int i = 0; i < 3; i++) send(8'(8'h10 + i), 0, 1, 1);
        check("R10 below 4", data_ready, 0);
        send(8'h13, 0, 1, 1);
        check("R10 at 4", data_ready, 1);
        trig = 2'b10;
        @(negedge clk);
        check("R10 below 8", data_ready, 0);
        for (int i = 4; i < 8; i++) send(8'(8'h10 + i), 0, 1, 1);
        check("R10 at 8", data_ready, 1);
        trig = 2'b11;
        @(negedge clk);
        check("R10 below 12", data_ready, 0);
        trig = 2'b00;
        for (int i = 0; i < 8; i++) begin
            check("R10 order", rd_data, 8'(8'h10 + i));
            pop();
        end

        // R8 overrun and R9 empty pops
        for (int i = 0; i < 16; i++) send(8'(8'h60 + i), 0, 1, 1);
        check("R8 no overrun yet", overrun, 0);
        send(8'hEE, 0, 1, 2);
        check("R8 overrun set", overrun, 1);
        status_read();
        check("R8 overrun cleared", overrun, 0);
        for (int i = 0; i < 16; i++) begin
            check("R8 stored kept", rd_data, 8'(8'h60 + i));
            pop();
        end
        check("R8 discarded", data_ready, 0);
        pop();
        pop();
        pop();
        check("R9 still empty", data_ready, 0);
        send(8'h77, 0, 1, 2);
        check("R9 pointer", rd_data, 8'h77);
        pop();

        // R12 non-FIFO mode
        fifo_mode = 1'b0;
        par_en = 1'b1; par_even = 1'b1;
        send(8'h11, 1, 1, 2);
        check("R12 ready", data_ready, 1);
        check("R11 nonfifo any_err", any_err, 0);
        check("R12 head pe", head_pe, 1);
        send(8'h22, 0, 1, 2);
        check("R12 overrun", overrun, 1);
        check("R12 held", rd_data, 8'h11);
        pop();
        check("R12 emptied", data_ready, 0);
        status_read();

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule